// File: doc/BRIEF.md
# Frame-Aware Byte FIFO with Retransmit Rewind

This block is a single-clock byte queue that sits between a DMA engine, which fills it, and a network peripheral, which drains it. With frame mode on, it records where each frame ends. It also keeps a saved pointer to the first byte of the frame the reader is working on. If the peripheral has to send a frame again, a retransmit pulse moves the read side back to that saved location.

Software programs the block through a small register port with two words. The first word holds the control fields: frame enable, completion hold, the release granularity and a one-shot write tag. The second word holds the saved frame-start pointer, and software can read or overwrite it. The tag tells the block what the next DMA write is. It can mark that write as the second-to-last byte of the frame, or as the closing status byte. Either way, the block places an end-of-frame marker on the correct byte.

Two request outputs pace the DMA side and the peripheral. Their release points scale with the granularity field. An optional hold can mute both requests after a frame is fully loaded, until the peripheral reports that the frame has been sent.

Top module: `frame_fifo_ctrl`

## Requirements
- R1: After reset, both register words read as zero, `rdEmpty` is 1, `wrFull` is 0, `reqHigh` is 0 and `reqLow` is 1.
- R2: Bytes leave in the order they were written. A read strobe while the queue is empty changes nothing.
- R3: `wrFull` is 1 when DEPTH bytes are held. A write in that state is dropped and does not disturb the stored bytes.
- R4: Control word layout (address 0): bit 0 is frame enable, bit 1 is completion hold, bits 4:2 are the granularity G, and bits 6:5 are the write tag. All other bits read as zero. Tag code 2'b10 marks the next accepted write as end-of-frame, so `rdEof` is 1 while that byte is at the read head. Any accepted write returns the tag to 2'b00.
- R5: Tag code 2'b01 marks the next accepted write as the second-to-last byte of the frame. The write after that carries the end-of-frame marker, and the 01-tagged byte itself does not.
- R6: The saved frame-start pointer (address 1, low DEPTH_LOG2+1 bits, including the wrap bit) changes only in two cases. It is written by software, or, with frame mode on, an end-of-frame byte is read; the pointer then moves to the location just past that byte.
- R7: A register write to address 1 loads the saved pointer, and a read of address 1 returns it.
- R8: A `retransmit` pulse with frame mode on moves the read head to the saved pointer, and the occupancy is recomputed from it on the next cycle. With frame mode off, the pulse is ignored.
- R9: `reqHigh` is 1 exactly when the occupancy is non-zero and at least G.
- R10: `reqLow` is 1 exactly when the free space is non-zero and at least 4·G.
- R11: With frame mode and completion hold both on, an accepted end-of-frame write drives both requests to 0 until a `txDone` pulse arrives.
- R12: With frame mode off, write tags mark no byte and reads never move the saved pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | DMA write strobe |
| wrData | input | 8 | DMA write byte |
| wrFull | output | 1 | Queue holds DEPTH bytes |
| rdReq | input | 1 | Peripheral read strobe |
| rdData | output | 8 | Byte at the read head |
| rdEof | output | 1 | Byte at the read head ends a frame |
| rdEmpty | output | 1 | Queue holds no bytes |
| retransmit | input | 1 | Rewind the read head to the saved frame start |
| txDone | input | 1 | Peripheral reports a frame sent |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the control word, 1 selects the saved pointer |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| reqHigh | output | 1 | Data-available request |
| reqLow | output | 1 | Space-available request |

## Verification
The request logic is checked with a table of granularity and fill-level pairs. The pairs sit on each side of the G and 4·G thresholds, and include G of zero, an empty queue and a full queue, so any off-by-one in either comparison shows up. The frame logic is checked with several short frames. One ends through the 01 tag and one through the 10 tag, and the resulting marker positions separate the two codes. A retransmit mid-frame, and a retransmit to a pointer loaded by software, each show whether the read head actually moved. The same pulses and tags are repeated with frame mode off, where nothing may change.

// File: rtl/ffifo_pkg.sv
package ffifo_pkg;

  // Strobes issued by the control module to the datapath each cycle
  typedef struct packed {
    logic push;       // accept wrData into storage
    logic pushEof;    // the accepted byte closes a frame
    logic pop;        // advance the read head
    logic popFrame;   // pop with frame mode on: boundary tracking active
    logic rewind;     // move read head to saved frame start
    logic lrfpWrite;  // software load of saved frame start
  } dpStrobe_t;

  localparam int TagNone   = 0;
  localparam int TagPenult = 1;
  localparam int TagStatus = 2;

endpackage

// File: rtl/ffifo_datapath.sv
module ffifo_datapath
  import ffifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
)(
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     stb,
  input  logic [7:0]    wrData,
  input  logic [PW-1:0] lrfpIn,
  output logic [7:0]    rdData,
  output logic          rdEof,
  output logic [PW-1:0] count,
  output logic [PW-1:0] lrfp
);

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] eofMark;
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;

  always_ff @(posedge clk) begin
    if (stb.push) begin
      mem[wrPtr[AW-1:0]]     <= wrData;
      eofMark[wrPtr[AW-1:0]] <= stb.pushEof;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      lrfp  <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + 1'b1;
      if (stb.rewind)   rdPtr <= lrfp;
      else if (stb.pop) rdPtr <= rdPtr + 1'b1;
      if (stb.lrfpWrite)                lrfp <= lrfpIn;
      else if (stb.popFrame && rdEof)   lrfp <= rdPtr + 1'b1;
    end
  end

  assign count  = wrPtr - rdPtr;
  assign rdData = mem[rdPtr[AW-1:0]];
  assign rdEof  = eofMark[rdPtr[AW-1:0]];

  assert_rewind_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.rewind |=> rdPtr == $past(lrfp));

  assert_lrfp_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!(stb.popFrame && rdEof) && !stb.lrfpWrite) |=> $stable(lrfp));

  assert_no_empty_pop_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> count != '0);

  assert_idle_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.push && !stb.pop && !stb.rewind) |=> $stable(count));

endmodule

// File: rtl/ffifo_control.sv
module ffifo_control
  import ffifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic          rdReq,
  input  logic          retransmit,
  input  logic          txDone,
  input  logic          regWrEn,
  input  logic          regAddr,
  input  logic [31:0]   regWrData,
  input  logic [PW-1:0] count,
  output dpStrobe_t     stb,
  output logic          wrFull,
  output logic          rdEmpty,
  output logic          reqHigh,
  output logic          reqLow,
  output logic [31:0]   ctrlWord
);

  localparam int CW = PW + 3;

  logic       frameEn;
  logic       compGate;
  logic [2:0] gran;
  logic [1:0] wfrCode;
  logic       lastArmed;
  logic       holdOff;
  logic       ctrlWrite;

  logic [CW-1:0] cntW, freeW, grW, gr4W;

  assign ctrlWrite = regWrEn && !regAddr;
  assign wrFull    = count == PW'(DEPTH);
  assign rdEmpty   = count == '0;

  always_comb begin
    stb           = '0;
    stb.push      = wrValid && !wrFull;
    stb.pushEof   = stb.push && frameEn &&
                    (wfrCode == 2'(TagStatus) || lastArmed);
    stb.rewind    = retransmit && frameEn;
    stb.pop       = rdReq && !rdEmpty && !stb.rewind;
    stb.popFrame  = stb.pop && frameEn;
    stb.lrfpWrite = regWrEn && regAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameEn   <= 1'b0;
      compGate  <= 1'b0;
      gran      <= '0;
      wfrCode   <= '0;
      lastArmed <= 1'b0;
      holdOff   <= 1'b0;
    end else begin
      if (ctrlWrite) begin
        frameEn  <= regWrData[0];
        compGate <= regWrData[1];
        gran     <= regWrData[4:2];
        wfrCode  <= regWrData[6:5];
      end else if (stb.push) begin
        wfrCode <= '0;
      end
      if (stb.push)
        lastArmed <= frameEn && (wfrCode == 2'(TagPenult));
      if (stb.pushEof && compGate) holdOff <= 1'b1;
      else if (txDone)             holdOff <= 1'b0;
    end
  end

  assign cntW  = CW'(count);
  assign freeW = CW'(DEPTH) - cntW;
  assign grW   = CW'(gran);
  assign gr4W  = grW << 2;

  assign reqHigh  = !holdOff && (cntW != '0)  && (cntW >= grW);
  assign reqLow   = !holdOff && (freeW != '0) && (freeW >= gr4W);
  assign ctrlWord = {25'd0, wfrCode, gran, compGate, frameEn};

  assert_tag_consumed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !ctrlWrite) |=> wfrCode == 2'b00);

  assert_hold_mutes_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pushEof && compGate) |=> (!reqHigh && !reqLow));

  assert_frame_off_no_tag_R12: assert property (@(posedge clk) disable iff (!rstN)
    !frameEn |-> (!stb.pushEof && !stb.rewind));

endmodule

// File: rtl/frame_fifo_ctrl.sv
module frame_fifo_ctrl
  import ffifo_pkg::*;
#(
  parameter int DEPTH = 512
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic [7:0]  wrData,
  output logic        wrFull,
  input  logic        rdReq,
  output logic [7:0]  rdData,
  output logic        rdEof,
  output logic        rdEmpty,
  input  logic        retransmit,
  input  logic        txDone,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        reqHigh,
  output logic        reqLow
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  dpStrobe_t     stb;
  logic [PW-1:0] count;
  logic [PW-1:0] lrfp;
  logic [31:0]   ctrlWord;

  ffifo_control #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdReq(rdReq),
    .retransmit(retransmit), .txDone(txDone), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .count(count), .stb(stb),
    .wrFull(wrFull), .rdEmpty(rdEmpty), .reqHigh(reqHigh), .reqLow(reqLow),
    .ctrlWord(ctrlWord)
  );

  ffifo_datapath #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .lrfpIn(regWrData[PW-1:0]), .rdData(rdData), .rdEof(rdEof),
    .count(count), .lrfp(lrfp)
  );

  assign regRdData = regAddr ? {{(32-PW){1'b0}}, lrfp} : ctrlWord;

endmodule

// File: tb/test_frame_fifo_ctrl.sv
module test_frame_fifo_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [7:0]  wrData = '0;
  logic        wrFull;
  logic        rdReq = 1'b0;
  logic [7:0]  rdData;
  logic        rdEof;
  logic        rdEmpty;
  logic        retransmit = 1'b0;
  logic        txDone = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqHigh;
  logic        reqLow;

  int nChecks = 0;
  int nFail   = 0;
  int fill    = 0;
  bit done    = 0;

  frame_fifo_ctrl #(.DEPTH(DEPTH)) i_frame_fifo_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrFull(wrFull),
    .rdReq(rdReq), .rdData(rdData), .rdEof(rdEof), .rdEmpty(rdEmpty),
    .retransmit(retransmit), .txDone(txDone), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .reqHigh(reqHigh), .reqLow(reqLow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [2:0] gr;
    logic [4:0] fill;
    logic       hi;
    logic       lo;
  } vec_t;

  // granularity, fill level, expected reqHigh, expected reqLow (DEPTH 16)
  localparam vec_t VEC [8] = '{
    '{3'd0, 5'd0,  1'b0, 1'b1},
    '{3'd2, 5'd1,  1'b0, 1'b1},
    '{3'd2, 5'd2,  1'b1, 1'b1},
    '{3'd3, 5'd4,  1'b1, 1'b1},
    '{3'd3, 5'd5,  1'b1, 1'b0},
    '{3'd7, 5'd6,  1'b0, 1'b0},
    '{3'd1, 5'd16, 1'b1, 1'b0},
    '{3'd4, 5'd0,  1'b0, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrValid = 0; rdReq = 0; retransmit = 0; txDone = 0; regWrEn = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    fill = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    wrValid = 1'b1; wrData = b;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic popChk(input string tag, input logic [7:0] expD, input logic expE);
    @(negedge clk);
    check(tag, rdData, expD);
    check(tag, rdEof, expE);
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic popAny();
    @(negedge clk);
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic regWrite(input logic a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    doReset();

    // R1 reset state
    @(negedge clk);
    regRead(1'b0, v); check("R1 ctrl", v, 0);
    regRead(1'b1, v); check("R1 lrfp", v, 0);
    check("R1 empty", rdEmpty, 1);
    check("R1 full", wrFull, 0);
    check("R1 reqHigh", reqHigh, 0);
    check("R1 reqLow", reqLow, 1);

    // R9 R10 table of granularity / fill pairs
    foreach (VEC[i]) begin
      regWrite(1'b0, {27'd0, VEC[i].gr, 2'b00});
      while (fill < int'(VEC[i].fill)) begin push(8'(fill)); fill++; end
      while (fill > int'(VEC[i].fill)) begin popAny(); fill--; end
      @(negedge clk);
      check($sformatf("R9 vec%0d", i), reqHigh, VEC[i].hi);
      check($sformatf("R10 vec%0d", i), reqLow, VEC[i].lo);
    end

    // R2 R3 ordering, overflow, underflow
    doReset();
    for (int i = 0; i < DEPTH; i++) push(8'(8'h80 + i));
    check("R3 full", wrFull, 1);
    push(8'hEE);
    for (int i = 0; i < DEPTH; i++) popChk("R2 order", 8'(8'h80 + i), 1'b0);
    check("R2 empty", rdEmpty, 1);
    popAny();
    check("R2 empty pop", rdEmpty, 1);
    push(8'h77);
    popChk("R2 after empty pop", 8'h77, 1'b0);

    // R4 R5 R6 R8 frame tags and retransmit
    doReset();
    regWrite(1'b0, 32'h21);               // frame on, tag 01
    push(8'h10);
    push(8'h11);
    push(8'h20);
    push(8'h21);
    regWrite(1'b0, 32'h41);               // frame on, tag 10
    @(negedge clk);
    regRead(1'b0, v); check("R4 tag readback", v, 32'h41);
    push(8'h22);
    regRead(1'b0, v); check("R4 tag cleared", v, 32'h01);
    popChk("R5 penult", 8'h10, 1'b0);
    popChk("R5 last", 8'h11, 1'b1);
    regRead(1'b1, v); check("R6 lrfp moved", v, 2);
    popChk("R2 f2b0", 8'h20, 1'b0);
    regRead(1'b1, v); check("R6 lrfp held", v, 2);
    popChk("R2 f2b1", 8'h21, 1'b0);
    pulse(retransmit);
    popChk("R8 rewind b0", 8'h20, 1'b0);
    popChk("R8 rewind b1", 8'h21, 1'b0);
    popChk("R4 status eof", 8'h22, 1'b1);
    regRead(1'b1, v); check("R6 lrfp end", v, 5);

    // R7 software pointer, R8 ignored with frame off
    regWrite(1'b1, 32'd3);
    regRead(1'b1, v); check("R7 lrfp write", v, 3);
    regWrite(1'b0, 32'h0);
    push(8'h30);
    pulse(retransmit);
    popChk("R8 ignored off", 8'h30, 1'b0);
    regWrite(1'b0, 32'h1);
    pulse(retransmit);
    popChk("R8 rewind to sw ptr", 8'h21, 1'b0);

    // R12 frame off: tag inert, pointer untouched
    doReset();
    regWrite(1'b0, 32'h40);
    @(negedge clk);
    regRead(1'b0, v); check("R7 ctrl readback", v, 32'h40);
    push(8'h40);
    regRead(1'b0, v); check("R4 tag cleared off", v, 0);
    popChk("R12 no eof", 8'h40, 1'b0);
    regRead(1'b1, v); check("R12 lrfp still", v, 0);

    // R11 completion hold
    doReset();
    regWrite(1'b0, 32'h07);               // frame, hold, G=1
    push(8'h50);
    check("R11 pre high", reqHigh, 1);
    check("R11 pre low", reqLow, 1);
    regWrite(1'b0, 32'h47);
    push(8'h51);
    check("R11 held high", reqHigh, 0);
    check("R11 held low", reqLow, 0);
    pulse(txDone);
    check("R11 released high", reqHigh, 1);
    check("R11 released low", reqLow, 1);

    summary();
  end

endmodule